// File: doc/BRIEF.md
# Parallel Configuration Target with Start-Up Sequencer

This block is the receiving end of a byte-wide configuration port. An external host presents one byte at a time on an 8-bit bus and toggles a data strobe clock; each rising edge of that strobe, observed against the system clock, delivers one byte. Accepted bytes are handed to the configuration store through a one-cycle write pulse. The block counts them against the image length fixed by a parameter and, while the count is short, holds an open-drain completion line low. The line is released on the clock edge that counts the final byte.

Completion of loading and start-up are kept apart. Once the completion line is released, a start-up counter waits for a fixed number of start-up clocks, 40 by default. The start-up clock is chosen at build time: either a single-cycle enable from an internal oscillator, or the rising edges of a user-supplied start-up clock pin. One bit of the first received byte decides whether an open-drain start-up-finished line is used. When that bit is set, the line is pulled low from the first byte until start-up ends. User mode is flagged on the edge that counts the last start-up clock, and the start-up-finished line is released on that same edge.

Top module: `cfg_port_target`

## Requirements
- R1: While `rst_n` is low, `done_pull_low` is 1, `initdone_pull_low` is 0, `user_mode` is 0 and `cfg_wr` is 0.
- R2: Each rising edge of `data_clk` seen at a `clk` edge, while loading, raises `cfg_wr` for exactly one cycle with `cfg_wdata` equal to `data_in`. `done_pull_low` stays 1 until `IMAGE_BYTES` bytes are accepted and drops to 0 on the edge that accepts the last one.
- R3: Bit `OPT_BIT` (default bit 0) of the first accepted byte enables the start-up-finished line. If it is 1, `initdone_pull_low` becomes 1 on the edge that accepts that byte. If it is 0, `initdone_pull_low` stays 0.
- R4: After release, `user_mode` becomes 1 on the edge that counts the `INIT_CYCLES`-th (default 40) start-up clock, and `initdone_pull_low` drops to 0 on that same edge.
- R5: With `STARTUP_SRC` = SRC_OSC (0), one start-up clock is counted for each `clk` cycle in which `osc_tick` is 1, and `user_clk` has no effect. With SRC_USER (1), one is counted for each rising edge of `user_clk`, and `osc_tick` has no effect.
- R6: Data strobes after release produce no `cfg_wr`, and they do not change `done_pull_low` or the start-up count. Start-up clocks that arrive before release are not counted.
- R7: The release of `done_pull_low` and the setting of `user_mode` hold until reset.
- R8: A reset during loading discards the bytes already received. A full `IMAGE_BYTES` bytes are needed again, and the first byte after reset supplies a fresh option bit.

Top module ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_clk | input | 1 | Byte strobe clock from the host |
| data_in | input | 8 | Configuration byte bus |
| osc_tick | input | 1 | Internal oscillator start-up enable, one tick per high cycle |
| user_clk | input | 1 | User start-up clock, counted on rising edges |
| cfg_wr | output | 1 | One-cycle write pulse for an accepted byte |
| cfg_wdata | output | 8 | Accepted byte |
| done_pull_low | output | 1 | 1 = completion line pulled low |
| initdone_pull_low | output | 1 | 1 = start-up-finished line pulled low |
| user_mode | output | 1 | Block has entered user mode |

## Verification
Random byte streams with random gaps between strobes are loaded over several rounds. The first byte's option bit alternates between rounds, which separates the enabled and disabled start-up-finished behaviour. Two instances run side by side, one per start-up clock source. Each gets 39 and then 40 ticks of its own source while the other source is also toggled, so that an off-by-one in the count shows apart from a wrong source selection. Surplus strobes after release, start-up ticks sent during loading, and a reset partway through an image each target one misbehaviour: counting past the image end, counting too early, and keeping stale progress.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
   typedef enum logic {
      SRC_OSC  = 1'b0,
      SRC_USER = 1'b1
   } startup_src_e;

   localparam int unsigned DEF_INIT_CYCLES = 40;
endpackage

// File: rtl/cfg_rise_det.sv
module cfg_rise_det (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sig;
   end

   assign rise = sig & ~prev_q;
endmodule

// File: rtl/cfg_byte_rx.sv
module cfg_byte_rx #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned IMAGE_BYTES = 16,
   parameter int unsigned OPT_BIT     = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [DATA_W-1:0] din,
   output logic              wr,
   output logic [DATA_W-1:0] wdata,
   output logic              image_done,
   output logic              opt_en
);
   localparam int unsigned CW = $clog2(IMAGE_BYTES + 1);
   localparam logic [CW-1:0] FULL = CW'(IMAGE_BYTES);

   logic [CW-1:0] cnt_q;
   logic          accept;

   assign image_done = (cnt_q == FULL);
   assign accept     = stb & ~image_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         opt_en <= 1'b0;
         wr     <= 1'b0;
         wdata  <= '0;
      end else begin
         wr <= accept;
         if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            wdata <= din;
            if (cnt_q == '0) opt_en <= din[OPT_BIT];
         end
      end
   end
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
   import cfg_pkg::*;
#(
   parameter startup_src_e STARTUP_SRC = SRC_OSC,
   parameter int unsigned  INIT_CYCLES = DEF_INIT_CYCLES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic osc_tick,
   input  logic user_clk,
   output logic tick,
   output logic user_mode
);
   localparam int unsigned TW = $clog2(INIT_CYCLES);
   localparam logic [TW-1:0] LAST = TW'(INIT_CYCLES - 1);

   logic          usr_rise;
   logic [TW-1:0] cnt_q;

   cfg_rise_det u_usr_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (user_clk),
      .rise (usr_rise)
   );

   generate
      if (STARTUP_SRC == SRC_USER) begin : g_user_src
         assign tick = usr_rise | (osc_tick & 1'b0);
      end else begin : g_osc_src
         assign tick = osc_tick | (usr_rise & 1'b0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         user_mode <= 1'b0;
      end else if (arm && !user_mode && tick) begin
         if (cnt_q == LAST) user_mode <= 1'b1;
         else               cnt_q     <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/cfg_port_target.sv
module cfg_port_target
   import cfg_pkg::*;
#(
   parameter int unsigned  DATA_W      = 8,
   parameter int unsigned  IMAGE_BYTES = 16,
   parameter int unsigned  OPT_BIT     = 0,
   parameter int unsigned  INIT_CYCLES = DEF_INIT_CYCLES,
   parameter startup_src_e STARTUP_SRC = SRC_OSC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_clk,
   input  logic [DATA_W-1:0] data_in,
   input  logic              osc_tick,
   input  logic              user_clk,
   output logic              cfg_wr,
   output logic [DATA_W-1:0] cfg_wdata,
   output logic              done_pull_low,
   output logic              initdone_pull_low,
   output logic              user_mode
);
   generate
      if (IMAGE_BYTES < 1) begin : g_bad_len
         $error("IMAGE_BYTES must be at least 1");
      end
      if (OPT_BIT >= DATA_W) begin : g_bad_opt
         $error("OPT_BIT must lie inside the data bus");
      end
      if (INIT_CYCLES < 2) begin : g_bad_init
         $error("INIT_CYCLES must be at least 2");
      end
   endgenerate

   logic byte_stb;
   logic image_done;
   logic opt_en;
   logic startup_tick;

   cfg_rise_det u_data_edge (
      .clk  (clk),
      .rst_n(rst_n),
      .sig  (data_clk),
      .rise (byte_stb)
   );

   cfg_byte_rx #(
      .DATA_W     (DATA_W),
      .IMAGE_BYTES(IMAGE_BYTES),
      .OPT_BIT    (OPT_BIT)
   ) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb       (byte_stb),
      .din       (data_in),
      .wr        (cfg_wr),
      .wdata     (cfg_wdata),
      .image_done(image_done),
      .opt_en    (opt_en)
   );

   cfg_startup_seq #(
      .STARTUP_SRC(STARTUP_SRC),
      .INIT_CYCLES(INIT_CYCLES)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm      (image_done),
      .osc_tick (osc_tick),
      .user_clk (user_clk),
      .tick     (startup_tick),
      .user_mode(user_mode)
   );

   assign done_pull_low     = ~image_done;
   assign initdone_pull_low = opt_en & ~user_mode;
endmodule

// File: rtl/cfg_port_target_chk.sv
module cfg_port_target_chk #(
   parameter int unsigned INIT_CYCLES = 40
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_wr,
   input logic done_pull_low,
   input logic initdone_pull_low,
   input logic user_mode,
   input logic startup_tick
);
   logic [15:0] ticks_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ticks_seen <= '0;
      else if (startup_tick && !done_pull_low && !user_mode && ticks_seen != 16'hFFFF)
         ticks_seen <= ticks_seen + 1'b1;
   end

   assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_pull_low |=> !done_pull_low);

   assert_user_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |=> user_mode);

   assert_user_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> !done_pull_low);

   assert_initdone_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      user_mode |-> !initdone_pull_low);

   assert_startup_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_mode) |-> (ticks_seen == 16'(INIT_CYCLES)));

   assert_initdone_only_loading_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(initdone_pull_low) |-> done_pull_low);

   assert_no_write_after_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !done_pull_low |=> !cfg_wr);
endmodule

bind cfg_port_target cfg_port_target_chk #(.INIT_CYCLES(INIT_CYCLES)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .cfg_wr           (cfg_wr),
   .done_pull_low    (done_pull_low),
   .initdone_pull_low(initdone_pull_low),
   .user_mode        (user_mode),
   .startup_tick     (startup_tick)
);

// File: tb/cfg_port_target_test.sv
module cfg_port_target_test;
   import cfg_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int NBYTES     = 16;
   localparam int NINIT      = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       data_clk = 1'b0;
   logic [7:0] data_in = '0;
   logic       osc_tick = 1'b0;
   logic       user_clk = 1'b0;

   logic       wr_a, wr_b, dn_a, dn_b, id_a, id_b, um_a, um_b;
   logic [7:0] wd_a, wd_b;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_port_target #(.IMAGE_BYTES(NBYTES), .INIT_CYCLES(NINIT), .STARTUP_SRC(SRC_OSC)) uut (
      .clk(clk), .rst_n(rst_n), .data_clk(data_clk), .data_in(data_in),
      .osc_tick(osc_tick), .user_clk(user_clk), .cfg_wr(wr_a), .cfg_wdata(wd_a),
      .done_pull_low(dn_a), .initdone_pull_low(id_a), .user_mode(um_a));

   cfg_port_target #(.IMAGE_BYTES(NBYTES), .INIT_CYCLES(NINIT), .STARTUP_SRC(SRC_USER)) uut_usr (
      .clk(clk), .rst_n(rst_n), .data_clk(data_clk), .data_in(data_in),
      .osc_tick(osc_tick), .user_clk(user_clk), .cfg_wr(wr_b), .cfg_wdata(wd_b),
      .done_pull_low(dn_b), .initdone_pull_low(id_b), .user_mode(um_b));

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_done_drive(input int sent);
      return (sent < NBYTES) ? 1 : 0;
   endfunction

   task automatic gap();
      repeat ($urandom_range(0, 3)) @(negedge clk);
   endtask

   // sends one byte; checks the write pulse right after the capturing edge
   task automatic send_byte(input logic [7:0] b, input bit expect_wr);
      @(negedge clk);
      data_in  = b;
      data_clk = 1'b1;
      @(negedge clk);
      data_clk = 1'b0;
      chk(expect_wr ? "R2 write pulse" : "R6 no write after release", int'(wr_a), int'(expect_wr));
      chk("R2 second instance write", int'(wr_b), int'(expect_wr));
      if (expect_wr) chk("R2 write data", int'(wd_a), int'(b));
      data_in = 8'($urandom);
      @(negedge clk);
      chk("R2 write one cycle", int'(wr_a), 0);
      gap();
   endtask

   task automatic pulse_osc();
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
      gap();
   endtask

   task automatic pulse_usr();
      @(negedge clk); user_clk = 1'b1;
      @(negedge clk); user_clk = 1'b0;
      gap();
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 done driven in reset", int'(dn_a), 1);
      chk("R1 done driven in reset usr", int'(dn_b), 1);
      chk("R1 initdone idle in reset", int'(id_a | id_b), 0);
      chk("R1 user_mode clear", int'(um_a | um_b), 0);
      chk("R1 no write", int'(wr_a | wr_b), 0);
      rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0C0F));
      for (int r = 0; r < 4; r++) begin
         bit         opt = (r % 2 == 1);
         logic [7:0] first;
         do_reset();
         if (r == 2) begin
            // partial image with option set, then reset: R8
            for (int k = 0; k < 5; k++) send_byte(8'($urandom) | 8'h01, 1'b1);
            chk("R8 option seen before reset", int'(id_a), 1);
            do_reset();
            chk("R8 option cleared by reset", int'(id_a | id_b), 0);
         end
         first = (8'($urandom) & 8'hFE) | {7'd0, opt};
         send_byte(first, 1'b1);
         chk("R3 initdone after first byte", int'(id_a), int'(opt));
         chk("R3 initdone after first byte usr", int'(id_b), int'(opt));
         // start-up clocks while loading must not count: R6
         for (int k = 0; k < 45; k++) begin pulse_osc(); end
         for (int k = 0; k < 45; k++) begin pulse_usr(); end
         for (int s = 2; s < NBYTES; s++) begin
            send_byte(8'($urandom), 1'b1);
            chk("R2 done held while loading", int'(dn_a), exp_done_drive(s));
         end
         chk("R8 full image needed after reset", int'(dn_b), 1);
         send_byte(8'($urandom), 1'b1);
         chk("R2 done released on last byte", int'(dn_a), exp_done_drive(NBYTES));
         chk("R2 done released usr", int'(dn_b), 0);
         chk("R6 no early user mode", int'(um_a | um_b), 0);
         for (int k = 0; k < 3; k++) send_byte(8'($urandom), 1'b0);
         chk("R6 done unaffected by extra strobes", int'(dn_a), 0);
         // user clock source instance
         for (int k = 0; k < NINIT - 1; k++) pulse_usr();
         chk("R4 usr not in user mode at 39", int'(um_b), 0);
         chk("R3 usr initdone held during startup", int'(id_b), int'(opt));
         pulse_usr();
         chk("R4 usr user mode at 40", int'(um_b), 1);
         chk("R4 usr initdone released", int'(id_b), 0);
         chk("R5 osc instance ignores user_clk", int'(um_a), 0);
         chk("R3 osc initdone still held", int'(id_a), int'(opt));
         // oscillator source instance
         for (int k = 0; k < NINIT - 1; k++) pulse_osc();
         chk("R4 osc not in user mode at 39", int'(um_a), 0);
         pulse_osc();
         chk("R4 osc user mode at 40", int'(um_a), 1);
         chk("R4 osc initdone released", int'(id_a), 0);
         for (int k = 0; k < 4; k++) begin pulse_osc(); pulse_usr(); end
         send_byte(8'($urandom), 1'b0);
         chk("R7 user mode sticky", int'(um_a & um_b), 1);
         chk("R7 done stays released", int'(dn_a | dn_b), 0);
      end
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule